// File: doc/BRIEF.md
# Partitioned Speculative Load/Store Queue

This block is the memory-ordering queue for one execution context that runs several threads taken from a single program. The queue is one storage array. Each thread, when it is started, receives a contiguous region that is reserved as a gap ahead of its memory operations. The regions follow thread age: an older thread's region always lies at lower indices than a younger thread's region. Because of this layout, queue index order is also program order across the whole context, and the dependence search reduces to index comparisons.

A speculative access is written into its thread's region and searches the other entries. A speculative load forwards data from the youngest older store to the same address. A speculative store that hits a younger thread's load which has already executed raises a squash request for that thread. The search result appears after a fixed number of cycles, together with a ready strobe that lets the scheduler wake dependent instructions. A non-speculative access is stored but does not search.

When a thread fills its region and a younger thread exists, the younger thread is squashed so that the full region can grow to the end of the queue. A squash removes the named thread and every thread younger than it in one cycle. Committing the oldest thread frees its region. When no thread is left, the queue restarts at index 0.

Top module: `lsq_spec_part`

## Requirements
- R1: After reset, `ready_o`, `squash_o` and `alloc_grant_o` are low and no thread is live.
- R2: An allocation is granted, combinationally in its request cycle, only if the size is non-zero, fewer than NUM_THR threads are live, the region fits below Q_DEPTH, and there is no squash or commit in the same cycle. Thread ids are handed out in order from 0.
- R3: A granted region starts where the previous region ends, so every entry of an older thread lies at a lower index than any entry of a younger thread.
- R4: A dispatch to a full region while a younger thread is live raises `squash_o` with `squash_thr_o` = thread+1 in the dispatch cycle. The region then extends to the end of the queue and the access is written.
- R5: A dispatch to a full region of the youngest live thread is dropped. It produces no ready strobe, no squash and no entry.
- R6: A speculative load returns `fwd_hit_o`=1 and the data of the highest-indexed older store with an equal address, taken from the load's own earlier entries or from older threads. Stores of younger threads are never forwarded.
- R7: A speculative store that matches the address of an executed load in a younger thread raises `squash_o` in its ready cycle, with `squash_thr_o` set to the oldest such thread.
- R8: A non-speculative load or store does no search and produces neither a ready strobe nor a squash.
- R9: For a speculative access presented in cycle c, `ready_o` is high for exactly one cycle, cycle c+SEARCH_LAT.
- R10: A squash of thread t, requested on `squash_cmd_i` or raised internally, frees the regions of t and of every younger thread in one cycle. The next allocation receives id t and starts at t's former base.
- R11: `commit_i` retires the oldest live thread, and its stores stop forwarding. Once the last thread is retired, allocation restarts from index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Start the next thread |
| alloc_size_i | input | IDX_W | Entries reserved for the new thread |
| alloc_grant_o | output | 1 | Allocation accepted this cycle |
| disp_valid_i | input | 1 | Memory access dispatch |
| disp_thr_i | input | THR_W | Thread id of the access |
| disp_store_i | input | 1 | 1 = store, 0 = load |
| disp_spec_i | input | 1 | Access belongs to a speculative thread |
| disp_addr_i | input | ADDR_W | Access address |
| disp_data_i | input | DATA_W | Store data |
| squash_cmd_i | input | 1 | External squash request |
| squash_cmd_thr_i | input | THR_W | Thread to squash (it and all younger) |
| commit_i | input | 1 | Retire the oldest live thread |
| squash_o | output | 1 | Squash raised by overflow or dependence violation |
| squash_thr_o | output | THR_W | Oldest thread to squash |
| ready_o | output | 1 | Search result valid |
| fwd_hit_o | output | 1 | Load found a forwarding store |
| fwd_data_o | output | DATA_W | Forwarded store data |

## Verification
The hardest state to reach is a region overflow while a younger thread still holds live entries in the slot just past the full region. The overflowing access must land in that slot in the same cycle as the kill, and its own search must skip the store that is being removed. The stimulus first fills the oldest region with speculative and non-speculative accesses and parks a store of the next thread at that region's first index. It then dispatches one more load to the oldest thread and checks the squash in the dispatch cycle, the forwarded data after the search latency, and a follow-up load that shows the killed store is gone. A violation is set up by executing a load in the youngest thread before an older thread stores to the same address.

// File: rtl/lsq_part_pkg.sv
package lsq_part_pkg;
  typedef enum logic {ACC_LOAD = 1'b0, ACC_STORE = 1'b1} acc_kind_e;
endpackage

// File: rtl/lsq_region_ctrl.sv
module lsq_region_ctrl #(
  parameter int NUM_THR = 3,
  parameter int Q_DEPTH = 24,
  parameter int THR_W   = 2,
  parameter int IDX_W   = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_valid_i,
  input  logic [IDX_W-1:0] alloc_size_i,
  input  logic             disp_valid_i,
  input  logic [THR_W-1:0] disp_thr_i,
  input  logic             cmd_sq_valid_i,
  input  logic [THR_W-1:0] cmd_sq_thr_i,
  input  logic             viol_valid_i,
  input  logic [THR_W-1:0] viol_thr_i,
  input  logic             commit_i,
  output logic             alloc_grant_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic             hw_sq_o,
  output logic [THR_W-1:0] hw_sq_thr_o,
  output logic             kill_en_o,
  output logic [IDX_W-1:0] kill_from_o,
  output logic             ret_en_o,
  output logic [IDX_W-1:0] ret_lo_o,
  output logic [IDX_W-1:0] ret_hi_o
);
  localparam int SLOTS = 1 << THR_W;

  logic [IDX_W-1:0] base_q [SLOTS];
  logic [IDX_W-1:0] size_q [SLOTS];
  logic [IDX_W-1:0] fill_q [SLOTS];
  logic [THR_W-1:0] head_q, tail_q;
  logic [IDX_W-1:0] qtail_q;

  logic             disp_live, full, younger, ovf, cmd_live, viol_live;
  logic             sq_any, extend, sq_empty, commit_ok;
  logic [THR_W-1:0] ovf_thr, sq_t;

  function automatic logic is_live(input logic [THR_W-1:0] t);
    return (t >= head_q) && (t < tail_q);
  endfunction

  always_comb begin
    disp_live = disp_valid_i && is_live(disp_thr_i);
    full      = fill_q[disp_thr_i] == size_q[disp_thr_i];
    younger   = ((THR_W+1)'(disp_thr_i) + 1'b1) < (THR_W+1)'(tail_q);
    ovf       = disp_live && full && younger;
    ovf_thr   = disp_thr_i + 1'b1;
    cmd_live  = cmd_sq_valid_i && is_live(cmd_sq_thr_i);
    viol_live = viol_valid_i && is_live(viol_thr_i);
    // hardware squash: oldest of violation and overflow
    hw_sq_o     = viol_live;
    hw_sq_thr_o = viol_thr_i;
    if (ovf && (!hw_sq_o || ovf_thr < hw_sq_thr_o)) begin
      hw_sq_o     = 1'b1;
      hw_sq_thr_o = ovf_thr;
    end
    sq_any = hw_sq_o;
    sq_t   = hw_sq_thr_o;
    if (cmd_live && (!sq_any || cmd_sq_thr_i < sq_t)) begin
      sq_any = 1'b1;
      sq_t   = cmd_sq_thr_i;
    end
    wr_en_o   = disp_live && (!full || younger) && !(sq_any && disp_thr_i >= sq_t);
    wr_idx_o  = base_q[disp_thr_i] + fill_q[disp_thr_i];
    extend    = wr_en_o && full;
    sq_empty  = sq_any && (sq_t == head_q);
    commit_ok = !sq_any && commit_i && (head_q < tail_q);
    alloc_grant_o = alloc_valid_i && !sq_any && !commit_i && (alloc_size_i != '0) &&
                    (tail_q < THR_W'(NUM_THR)) &&
                    (({1'b0, qtail_q} + {1'b0, alloc_size_i}) <= (IDX_W+1)'(Q_DEPTH));
    kill_en_o   = sq_any;
    kill_from_o = base_q[sq_t];
    ret_en_o    = commit_ok;
    ret_lo_o    = base_q[head_q];
    ret_hi_o    = base_q[head_q] + size_q[head_q];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      qtail_q <= '0;
      for (int s = 0; s < SLOTS; s++) begin
        base_q[s] <= '0;
        size_q[s] <= '0;
        fill_q[s] <= '0;
      end
    end else begin
      if (sq_any) begin
        if (sq_empty) begin
          head_q  <= '0;
          tail_q  <= '0;
          qtail_q <= '0;
        end else begin
          tail_q  <= sq_t;
          qtail_q <= extend ? IDX_W'(Q_DEPTH) : base_q[sq_t];
          if (extend) size_q[disp_thr_i] <= IDX_W'(Q_DEPTH) - base_q[disp_thr_i];
        end
      end else if (commit_ok) begin
        if (head_q + 1'b1 == tail_q) begin
          head_q  <= '0;
          tail_q  <= '0;
          qtail_q <= '0;
        end else begin
          head_q <= head_q + 1'b1;
        end
      end else if (alloc_grant_o) begin
        base_q[tail_q] <= qtail_q;
        size_q[tail_q] <= alloc_size_i;
        fill_q[tail_q] <= '0;
        tail_q         <= tail_q + 1'b1;
        qtail_q        <= qtail_q + alloc_size_i;
      end
      if (wr_en_o) fill_q[disp_thr_i] <= fill_q[disp_thr_i] + 1'b1;
    end
  end

  p_alloc_fit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_grant_o |=> (qtail_q <= IDX_W'(Q_DEPTH)) && (tail_q == $past(tail_q) + 1'b1));

  p_squash_frees_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sq_any |=> (tail_q == $past(sq_t)) || (tail_q == '0));

  p_commit_head_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_ok |=> (head_q == $past(head_q) + 1'b1) || (tail_q == '0));

  p_ovf_squash_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf |-> hw_sq_o && (hw_sq_thr_o <= ovf_thr));

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr_chk
    p_fill_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      is_live(THR_W'(t)) |-> fill_q[t] <= size_q[t]);
    if (t + 1 < NUM_THR) begin : g_ord
      p_region_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (is_live(THR_W'(t)) && is_live(THR_W'(t + 1))) |-> (base_q[t] + size_q[t] <= base_q[t+1]));
    end
  end
endmodule

// File: rtl/lsq_entry_array.sv
module lsq_entry_array
  import lsq_part_pkg::*;
#(
  parameter int Q_DEPTH = 24,
  parameter int IDX_W   = 5,
  parameter int THR_W   = 2,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [THR_W-1:0]  wr_thr_i,
  input  acc_kind_e         wr_kind_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              kill_en_i,
  input  logic [IDX_W-1:0]  kill_from_i,
  input  logic              ret_en_i,
  input  logic [IDX_W-1:0]  ret_lo_i,
  input  logic [IDX_W-1:0]  ret_hi_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] hit_data_o,
  output logic              viol_o,
  output logic [THR_W-1:0]  viol_thr_o
);
  localparam int ENTRIES = 1 << IDX_W;

  logic              valid_q [ENTRIES];
  acc_kind_e         kind_q  [ENTRIES];
  logic [THR_W-1:0]  thr_q   [ENTRIES];
  logic [ADDR_W-1:0] addr_q  [ENTRIES];
  logic [DATA_W-1:0] data_q  [ENTRIES];

  // index order equals program order across threads
  always_comb begin
    hit_o      = 1'b0;
    hit_data_o = '0;
    viol_o     = 1'b0;
    viol_thr_o = '0;
    for (int i = 0; i < Q_DEPTH; i++) begin
      if (wr_kind_i == ACC_LOAD && valid_q[i] && kind_q[i] == ACC_STORE &&
          addr_q[i] == wr_addr_i && IDX_W'(i) < wr_idx_i) begin
        hit_o      = 1'b1;
        hit_data_o = data_q[i];
      end
    end
    for (int i = Q_DEPTH - 1; i >= 0; i--) begin
      if (wr_kind_i == ACC_STORE && valid_q[i] && kind_q[i] == ACC_LOAD &&
          addr_q[i] == wr_addr_i && IDX_W'(i) > wr_idx_i) begin
        viol_o     = 1'b1;
        viol_thr_o = thr_q[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) valid_q[i] <= 1'b0;
    end else begin
      for (int i = 0; i < Q_DEPTH; i++) begin
        if ((kill_en_i && IDX_W'(i) >= kill_from_i) ||
            (ret_en_i && IDX_W'(i) >= ret_lo_i && IDX_W'(i) < ret_hi_i))
          valid_q[i] <= 1'b0;
      end
      if (wr_en_i) valid_q[wr_idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      kind_q[wr_idx_i] <= wr_kind_i;
      thr_q[wr_idx_i]  <= wr_thr_i;
      addr_q[wr_idx_i] <= wr_addr_i;
      data_q[wr_idx_i] <= wr_data_i;
    end
  end

  p_slot_free_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (!valid_q[wr_idx_i] || (kill_en_i && wr_idx_i >= kill_from_i)));

  p_write_lands_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> valid_q[$past(wr_idx_i)]);
endmodule

// File: rtl/lsq_search_pipe.sv
module lsq_search_pipe #(
  parameter int LAT    = 3,
  parameter int DATA_W = 32,
  parameter int THR_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic              hit_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              viol_i,
  input  logic [THR_W-1:0]  vthr_i,
  output logic              vld_o,
  output logic              hit_o,
  output logic [DATA_W-1:0] data_o,
  output logic              viol_o,
  output logic [THR_W-1:0]  vthr_o
);
  localparam int CNT_W = $clog2(LAT + 2);

  logic              vld_q  [LAT];
  logic              hit_q  [LAT];
  logic [DATA_W-1:0] data_q [LAT];
  logic              viol_q [LAT];
  logic [THR_W-1:0]  vthr_q [LAT];

  for (genvar k = 0; k < LAT; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[k]  <= 1'b0;
        hit_q[k]  <= 1'b0;
        data_q[k] <= '0;
        viol_q[k] <= 1'b0;
        vthr_q[k] <= '0;
      end else if (k == 0) begin
        vld_q[k]  <= vld_i;
        hit_q[k]  <= hit_i;
        data_q[k] <= data_i;
        viol_q[k] <= viol_i;
        vthr_q[k] <= vthr_i;
      end else begin
        vld_q[k]  <= vld_q[k-1];
        hit_q[k]  <= hit_q[k-1];
        data_q[k] <= data_q[k-1];
        viol_q[k] <= viol_q[k-1];
        vthr_q[k] <= vthr_q[k-1];
      end
    end
  end

  assign vld_o  = vld_q[LAT-1];
  assign hit_o  = hit_q[LAT-1];
  assign data_o = data_q[LAT-1];
  assign viol_o = viol_q[LAT-1] && vld_q[LAT-1];
  assign vthr_o = vthr_q[LAT-1];

  // in-flight count, used only by the checks below
  logic [CNT_W-1:0] inflight_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inflight_q <= '0;
    else         inflight_q <= inflight_q + CNT_W'(vld_i) - CNT_W'(vld_o);
  end

  p_ready_has_search_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> inflight_q != '0);

  p_inflight_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight_q <= CNT_W'(LAT));
endmodule

// File: rtl/lsq_spec_part.sv
module lsq_spec_part
  import lsq_part_pkg::*;
#(
  parameter int NUM_THR    = 3,
  parameter int Q_DEPTH    = 24,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int SEARCH_LAT = 3,
  localparam int THR_W     = $clog2(NUM_THR + 1),
  localparam int IDX_W     = $clog2(Q_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_valid_i,
  input  logic [IDX_W-1:0]  alloc_size_i,
  output logic              alloc_grant_o,
  input  logic              disp_valid_i,
  input  logic [THR_W-1:0]  disp_thr_i,
  input  logic              disp_store_i,
  input  logic              disp_spec_i,
  input  logic [ADDR_W-1:0] disp_addr_i,
  input  logic [DATA_W-1:0] disp_data_i,
  input  logic              squash_cmd_i,
  input  logic [THR_W-1:0]  squash_cmd_thr_i,
  input  logic              commit_i,
  output logic              squash_o,
  output logic [THR_W-1:0]  squash_thr_o,
  output logic              ready_o,
  output logic              fwd_hit_o,
  output logic [DATA_W-1:0] fwd_data_o
);
  logic              wr_en, kill_en, ret_en;
  logic [IDX_W-1:0]  wr_idx, kill_from, ret_lo, ret_hi;
  logic              s_hit, s_viol, p_viol;
  logic [DATA_W-1:0] s_data;
  logic [THR_W-1:0]  s_vthr, p_vthr;
  acc_kind_e         kind;

  assign kind = disp_store_i ? ACC_STORE : ACC_LOAD;

  lsq_region_ctrl #(.NUM_THR(NUM_THR), .Q_DEPTH(Q_DEPTH), .THR_W(THR_W), .IDX_W(IDX_W)) u_ctrl (
    .clk_i, .rst_ni,
    .alloc_valid_i, .alloc_size_i,
    .disp_valid_i, .disp_thr_i,
    .cmd_sq_valid_i(squash_cmd_i), .cmd_sq_thr_i(squash_cmd_thr_i),
    .viol_valid_i(p_viol), .viol_thr_i(p_vthr),
    .commit_i,
    .alloc_grant_o,
    .wr_en_o(wr_en), .wr_idx_o(wr_idx),
    .hw_sq_o(squash_o), .hw_sq_thr_o(squash_thr_o),
    .kill_en_o(kill_en), .kill_from_o(kill_from),
    .ret_en_o(ret_en), .ret_lo_o(ret_lo), .ret_hi_o(ret_hi)
  );

  lsq_entry_array #(.Q_DEPTH(Q_DEPTH), .IDX_W(IDX_W), .THR_W(THR_W),
                    .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_thr_i(disp_thr_i), .wr_kind_i(kind),
    .wr_addr_i(disp_addr_i), .wr_data_i(disp_data_i),
    .kill_en_i(kill_en), .kill_from_i(kill_from),
    .ret_en_i(ret_en), .ret_lo_i(ret_lo), .ret_hi_i(ret_hi),
    .hit_o(s_hit), .hit_data_o(s_data), .viol_o(s_viol), .viol_thr_o(s_vthr)
  );

  lsq_search_pipe #(.LAT(SEARCH_LAT), .DATA_W(DATA_W), .THR_W(THR_W)) u_pipe (
    .clk_i, .rst_ni,
    .vld_i(wr_en && disp_spec_i),
    .hit_i(s_hit), .data_i(s_data), .viol_i(s_viol), .vthr_i(s_vthr),
    .vld_o(ready_o), .hit_o(fwd_hit_o), .data_o(fwd_data_o),
    .viol_o(p_viol), .vthr_o(p_vthr)
  );

  p_squash_live_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_o |-> (squash_thr_o != '0));

  p_fwd_on_ready_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_hit_o && !ready_o |-> !$past(ready_o) || $stable(fwd_hit_o));
endmodule

// File: tb/lsq_spec_part_test.sv
module lsq_spec_part_test;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0;
  logic [4:0]  alloc_size = '0;
  logic        alloc_grant;
  logic        disp_valid = 1'b0;
  logic [1:0]  disp_thr = '0;
  logic        disp_store = 1'b0;
  logic        disp_spec = 1'b0;
  logic [15:0] disp_addr = '0;
  logic [31:0] disp_data = '0;
  logic        sq_cmd = 1'b0;
  logic [1:0]  sq_cmd_thr = '0;
  logic        commit = 1'b0;
  logic        squash;
  logic [1:0]  squash_thr;
  logic        ready;
  logic        fwd_hit;
  logic [31:0] fwd_data;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  lsq_spec_part uut (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_valid_i(alloc_valid), .alloc_size_i(alloc_size), .alloc_grant_o(alloc_grant),
    .disp_valid_i(disp_valid), .disp_thr_i(disp_thr), .disp_store_i(disp_store),
    .disp_spec_i(disp_spec), .disp_addr_i(disp_addr), .disp_data_i(disp_data),
    .squash_cmd_i(sq_cmd), .squash_cmd_thr_i(sq_cmd_thr), .commit_i(commit),
    .squash_o(squash), .squash_thr_o(squash_thr),
    .ready_o(ready), .fwd_hit_o(fwd_hit), .fwd_data_o(fwd_data)
  );

  typedef struct {
    bit          is_ld;
    bit          hit;
    logic [31:0] data;
    bit          sq;
    logic [1:0]  sqt;
    string       req;
  } exp_t;
  exp_t sb[$];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("[TB] FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compare each ready strobe with the oldest expected result
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && ready) begin
        if (sb.size() == 0) chk("R9 unexpected ready", 64'(ready), 64'd0);
        else begin
          e = sb.pop_front();
          chk({e.req, " hit"}, 64'(fwd_hit), 64'(e.hit));
          if (e.is_ld && e.hit) chk({e.req, " data"}, 64'(fwd_data), 64'(e.data));
          chk({e.req, " squash"}, 64'(squash), 64'(e.sq));
          if (e.sq) chk({e.req, " squash thr"}, 64'(squash_thr), 64'(e.sqt));
        end
      end
    end
  end

  task automatic do_alloc(input logic [4:0] sz, input bit exp_g, input string req);
    @(negedge clk);
    alloc_valid = 1'b1;
    alloc_size  = sz;
    #1 chk(req, 64'(alloc_grant), 64'(exp_g));
    @(negedge clk);
    alloc_valid = 1'b0;
  endtask

  // spec access: pushes expectation, checks the latency window
  task automatic do_spec(input logic [1:0] thr, input bit st, input logic [15:0] a,
                         input logic [31:0] d, input bit e_hit, input logic [31:0] e_data,
                         input bit e_sq, input logic [1:0] e_sqt, input string req);
    exp_t e;
    e.is_ld = !st; e.hit = e_hit; e.data = e_data; e.sq = e_sq; e.sqt = e_sqt; e.req = req;
    sb.push_back(e);
    @(negedge clk);
    disp_valid = 1'b1; disp_thr = thr; disp_store = st; disp_spec = 1'b1;
    disp_addr = a; disp_data = d;
    for (int k = 1; k <= LAT; k++) begin
      @(negedge clk);
      disp_valid = 1'b0;
      if (k < LAT) chk("R9 early ready", 64'(ready), 64'd0);
    end
  endtask

  // access expected to produce no search (non-spec or dropped)
  task automatic do_quiet(input logic [1:0] thr, input bit st, input bit spec,
                          input logic [15:0] a, input logic [31:0] d, input string req);
    @(negedge clk);
    disp_valid = 1'b1; disp_thr = thr; disp_store = st; disp_spec = spec;
    disp_addr = a; disp_data = d;
    #1 chk({req, " squash"}, 64'(squash), 64'd0);
    for (int k = 1; k <= LAT + 1; k++) begin
      @(negedge clk);
      disp_valid = 1'b0;
      chk({req, " ready"}, 64'(ready), 64'd0);
    end
  endtask

  task automatic do_cmd(input bit is_sq, input logic [1:0] t);
    @(negedge clk);
    sq_cmd = is_sq; sq_cmd_thr = t; commit = !is_sq;
    @(negedge clk);
    sq_cmd = 1'b0; commit = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("[TB] FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  localparam logic [15:0] A = 16'h0010, B = 16'h0020, C = 16'h0030;

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready", 64'(ready), 64'd0);
    chk("R1 squash", 64'(squash), 64'd0);
    chk("R1 grant", 64'(alloc_grant), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after release", 64'(ready), 64'd0);
    // R1: no thread live, dispatch ignored
    do_quiet(2'd0, 1'b0, 1'b1, A, 32'h0, "R1 dispatch with no thread");

    // regions T0:[0,4) T1:[4,8) T2:[8,12)
    do_alloc(5'd4, 1'b1, "R2 alloc t0");
    do_alloc(5'd4, 1'b1, "R2 alloc t1");
    do_alloc(5'd20, 1'b0, "R2 alloc too large");
    do_alloc(5'd0, 1'b0, "R2 alloc zero size");
    do_alloc(5'd4, 1'b1, "R2 alloc t2");
    do_alloc(5'd4, 1'b0, "R2 alloc beyond thread limit");

    do_spec(2'd0, 1'b1, A, 32'hD1, 1'b0, 32'h0, 1'b0, 2'd0, "R9 t0 store");
    do_spec(2'd0, 1'b0, A, 32'h0, 1'b1, 32'hD1, 1'b0, 2'd0, "R6 own older store");
    do_spec(2'd1, 1'b1, A, 32'hD2, 1'b0, 32'h0, 1'b0, 2'd0, "R9 t1 store");
    do_spec(2'd1, 1'b0, A, 32'h0, 1'b1, 32'hD2, 1'b0, 2'd0, "R6 youngest older store");
    do_spec(2'd0, 1'b0, A, 32'h0, 1'b1, 32'hD1, 1'b0, 2'd0, "R3 younger store not forwarded");
    do_spec(2'd1, 1'b0, B, 32'h0, 1'b0, 32'h0, 1'b0, 2'd0, "R6 no address match");
    do_spec(2'd2, 1'b0, C, 32'h0, 1'b0, 32'h0, 1'b0, 2'd0, "R6 t2 load");
    do_spec(2'd1, 1'b1, C, 32'hC1, 1'b0, 32'h0, 1'b1, 2'd2, "R7 violation");

    // R8: non-spec load fills t0 (index 3), no search
    do_quiet(2'd0, 1'b0, 1'b0, A, 32'h0, "R8 non-spec load");

    // R4: t0 full, t1 live -> overflow squash in dispatch cycle
    begin
      exp_t e;
      e.is_ld = 1'b1; e.hit = 1'b1; e.data = 32'hD1; e.sq = 1'b0; e.sqt = 2'd0; e.req = "R4 overflow load";
      sb.push_back(e);
      @(negedge clk);
      disp_valid = 1'b1; disp_thr = 2'd0; disp_store = 1'b0; disp_spec = 1'b1; disp_addr = A;
      #1 chk("R4 overflow squash", 64'(squash), 64'd1);
      chk("R4 overflow squash thr", 64'(squash_thr), 64'd1);
      for (int k = 1; k <= LAT; k++) begin
        @(negedge clk);
        disp_valid = 1'b0;
      end
    end
    do_spec(2'd0, 1'b0, A, 32'h0, 1'b1, 32'hD1, 1'b0, 2'd0, "R10 killed store gone after overflow");
    do_spec(2'd0, 1'b1, B, 32'hB0, 1'b0, 32'h0, 1'b0, 2'd0, "R4 region extended");
    do_spec(2'd0, 1'b0, B, 32'h0, 1'b1, 32'hB0, 1'b0, 2'd0, "R4 extended entries usable");

    do_cmd(1'b1, 2'd0);
    do_alloc(5'd2, 1'b1, "R10 restart after full squash");
    do_spec(2'd0, 1'b1, A, 32'hD3, 1'b0, 32'h0, 1'b0, 2'd0, "R9 store d3");
    do_spec(2'd0, 1'b1, A, 32'hD4, 1'b0, 32'h0, 1'b0, 2'd0, "R9 store d4");
    do_quiet(2'd0, 1'b1, 1'b1, A, 32'hD5, "R5 youngest full dropped");
    do_alloc(5'd4, 1'b1, "R2 alloc t1 after t0");
    do_spec(2'd1, 1'b0, A, 32'h0, 1'b1, 32'hD4, 1'b0, 2'd0, "R5 dropped store not forwarded");
    do_cmd(1'b0, 2'd0);
    do_spec(2'd1, 1'b0, A, 32'h0, 1'b0, 32'h0, 1'b0, 2'd0, "R11 committed store not forwarded");
    do_cmd(1'b0, 2'd0);
    do_alloc(5'd24, 1'b1, "R11 restart from index 0");

    do_cmd(1'b1, 2'd0);
    do_alloc(5'd8, 1'b1, "R2 alloc t0 size 8");
    do_alloc(5'd8, 1'b1, "R2 alloc t1 size 8");
    do_alloc(5'd8, 1'b1, "R2 alloc t2 size 8");
    do_spec(2'd1, 1'b1, A, 32'hD7, 1'b0, 32'h0, 1'b0, 2'd0, "R9 t1 store d7");
    do_spec(2'd2, 1'b0, A, 32'h0, 1'b1, 32'hD7, 1'b0, 2'd0, "R6 older thread store");
    do_cmd(1'b1, 2'd1);
    do_alloc(5'd16, 1'b1, "R10 younger regions freed");
    do_spec(2'd1, 1'b0, A, 32'h0, 1'b0, 32'h0, 1'b0, 2'd0, "R10 squashed store gone");

    repeat (LAT + 2) @(negedge clk);
    chk("R9 all results seen", 64'(sb.size()), 64'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule